// File: doc/BRIEF.md
# SDRAM Power-Up Initialization Sequencer

This block takes a single-rank, four-bank, 32-bit SDRAM from reset to a state where it accepts normal commands. Out of reset it holds the clock-enable pin low and drives only NOP on the command pins while a long power-up delay runs down. Partway through that delay it raises clock enable and keeps sending NOPs until the delay ends. It then issues one precharge to every bank, a parameter-set number of auto-refresh commands and finally a mode-register load carrying a parameter-set op-code. Each command is followed by exactly the programmed number of idle cycles before the next one.

All delays are cycle counts given as parameters: the power-up length, the cycle at which clock enable rises, the precharge, refresh and mode-load recovery times, the number of refreshes and the mode word. Every output comes straight from a flop, so the memory samples stable levels at the next rising edge. When the sequence is over, a done flag goes high and stays high until the next synchronous, active-high reset, which restarts the whole sequence. The block has no data stream, so all pins are plain control and status levels with no handshake.

Command codes on (chip-select, row strobe, column strobe, write enable), all active low: NOP = 0111, PRECHARGE = 0010, AUTO REFRESH = 0001, LOAD MODE = 0000.

Top module: `sdram_init_seq`

## Requirements
- R1: While reset is high, and in the cycle just after the last reset edge (slot 0), clock enable is 0, the command is NOP (0111) and the done flag is 0.
- R2: Counting slot 0 as the first output cycle after reset, slots 0 to PWRUP_CYC-1 carry only NOP, and PRECHARGE appears in slot PWRUP_CYC.
- R3: Clock enable is 0 in slots before CKE_AT_CYC, becomes 1 in slot CKE_AT_CYC, and never returns to 0 until the next reset.
- R4: The PRECHARGE command (0010) has address bit AP_BIT (default 10) high, every other address bit 0 and bank address 00, so all banks are precharged.
- R5: Exactly REF_COUNT AUTO REFRESH commands (0001) follow. The first comes TRP_CYC slots after PRECHARGE and each later one TRFC_CYC slots after the one before, with only NOP in between.
- R6: LOAD MODE (0000) comes TRFC_CYC slots after the last refresh, with bank address 00 and the address bus equal to MODE_WORD.
- R7: The done flag rises TMRD_CYC slots after LOAD MODE, with only NOP in between. From then on it stays 1 and the command stays NOP.
- R8: A reset raised at any point in the sequence returns the outputs to the R1 state at the next edge, and the full sequence then restarts with the same timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all outputs change on its rising edge |
| rst | input | 1 | Synchronous active-high reset, restarts the sequence |
| sd_cke | output | 1 | SDRAM clock enable |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_ba | output | BA_W | Bank address, always 00 |
| sd_addr | output | AW | Address bus: precharge-all bit or mode op-code |
| init_done | output | 1 | High once the sequence has completed |

## Verification
On every cycle, the assertions check that clock enable and the done flag never fall outside reset, and that no command other than NOP goes out while clock enable is low or after done. They also check that every precharge carries the all-banks bit with a zero bank address, that every mode load carries bank 00 and the mode word, and that the refresh counter stays in range. The exact slot of each command, and so the exact gaps, the number of refreshes and the cycle at which clock enable rises, can only be shown by the bench's scenarios. The bench walks an expected-event table for two parameter sets, one of them with one-cycle minimum gaps and four refreshes. Restart after a reset in the middle of the sequence is also a bench scenario.

// File: rtl/sinit_pkg.sv
package sinit_pkg;

  // {cs_n, ras_n, cas_n, we_n}
  typedef enum logic [3:0] {
    CMD_LMR = 4'b0000,
    CMD_REF = 4'b0001,
    CMD_PRE = 4'b0010,
    CMD_NOP = 4'b0111
  } sd_cmd_e;

  typedef enum logic [2:0] {
    ST_PWRUP = 3'd0,
    ST_PRE   = 3'd1,
    ST_REF   = 3'd2,
    ST_LMR   = 3'd3,
    ST_DONE  = 3'd4
  } init_st_e;

  function automatic sd_cmd_e cmd_for(init_st_e s);
    case (s)
      ST_PRE:  return CMD_PRE;
      ST_REF:  return CMD_REF;
      ST_LMR:  return CMD_LMR;
      default: return CMD_NOP;
    endcase
  endfunction

endpackage

// File: rtl/sinit_timer.sv
module sinit_timer #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [CW-1:0] rst_val,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic [CW-1:0] cnt_d,
  output logic          zero
);
  logic [CW-1:0] cnt_q;

  always_comb begin
    if (rst)              cnt_d = rst_val;
    else if (load)        cnt_d = load_val;
    else if (cnt_q != '0) cnt_d = cnt_q - 1'b1;
    else                  cnt_d = cnt_q;
  end

  always_ff @(posedge clk) cnt_q <= cnt_d;

  assign zero = (cnt_q == '0);

  // R2: a running window only ends through a count-down step, never a jump
  a_r2_no_skip: assert property (@(posedge clk) disable iff (rst)
    (!zero && !load) |=> (cnt_q == $past(cnt_q) - 1'b1) || $past(rst));

endmodule

// File: rtl/sinit_fsm.sv
module sinit_fsm
  import sinit_pkg::*;
#(
  parameter int CW        = 8,
  parameter int RW        = 2,
  parameter int TRP_CYC   = 2,
  parameter int TRFC_CYC  = 7,
  parameter int TMRD_CYC  = 2,
  parameter int REF_COUNT = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tmr_zero,
  output init_st_e      st_d,
  output logic          issue_d,
  output logic          load,
  output logic [CW-1:0] load_val
);
  localparam logic [CW-1:0] TRP_LD  = CW'(TRP_CYC - 1);
  localparam logic [CW-1:0] TRFC_LD = CW'(TRFC_CYC - 1);
  localparam logic [CW-1:0] TMRD_LD = CW'(TMRD_CYC - 1);
  localparam logic [RW-1:0] REF_LD  = RW'(REF_COUNT - 1);

  init_st_e      st_q;
  logic [RW-1:0] refs_q, refs_d;

  always_comb begin
    st_d     = st_q;
    refs_d   = refs_q;
    issue_d  = 1'b0;
    load     = 1'b0;
    load_val = '0;
    if (rst) begin
      st_d   = ST_PWRUP;
      refs_d = '0;
    end else if (tmr_zero) begin
      case (st_q)
        ST_PWRUP: begin
          st_d = ST_PRE;  load = 1'b1; load_val = TRP_LD;  issue_d = 1'b1;
        end
        ST_PRE: begin
          st_d = ST_REF;  load = 1'b1; load_val = TRFC_LD; issue_d = 1'b1;
          refs_d = REF_LD;
        end
        ST_REF: begin
          load = 1'b1; issue_d = 1'b1;
          if (refs_q == '0) begin
            st_d = ST_LMR; load_val = TMRD_LD;
          end else begin
            refs_d = refs_q - 1'b1; load_val = TRFC_LD;
          end
        end
        ST_LMR:  st_d = ST_DONE;
        default: st_d = ST_DONE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    st_q   <= st_d;
    refs_q <= refs_d;
  end

  // R5: remaining-refresh count never exceeds the programmed number
  a_r5_refs_range: assert property (@(posedge clk) disable iff (rst)
    refs_q <= REF_LD);

  // R7: completion is terminal until reset
  a_r7_done_terminal: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_DONE) |=> (st_q == ST_DONE));

endmodule

// File: rtl/sinit_cmd_reg.sv
module sinit_cmd_reg
  import sinit_pkg::*;
#(
  parameter int           CW         = 8,
  parameter int           AW         = 11,
  parameter int           BA_W       = 2,
  parameter int           AP_BIT     = 10,
  parameter int           PWRUP_CYC  = 10000,
  parameter int           CKE_AT_CYC = 5000,
  parameter logic [AW-1:0] MODE_WORD = 11'h032
) (
  input  logic            clk,
  input  logic            rst,
  input  init_st_e        st_d,
  input  logic            issue_d,
  input  logic [CW-1:0]   cnt_d,
  output logic            cke_q,
  output logic [3:0]      cmd_q,
  output logic [BA_W-1:0] ba_q,
  output logic [AW-1:0]   addr_q,
  output logic            done_q
);
  // count value at which CKE must be high inside the power-up window
  localparam logic [CW-1:0] CKE_LIM  = CW'(PWRUP_CYC - 1 - CKE_AT_CYC);
  localparam logic [AW-1:0] PRE_ADDR = AW'(1) << AP_BIT;

  logic            cke_d, done_d;
  logic [3:0]      cmd_d;
  logic [AW-1:0]   addr_d;

  always_comb begin
    cmd_d  = issue_d ? cmd_for(st_d) : CMD_NOP;
    addr_d = '0;
    if (issue_d && st_d == ST_PRE) addr_d = PRE_ADDR;
    if (issue_d && st_d == ST_LMR) addr_d = MODE_WORD;
    cke_d  = !rst && ((st_d != ST_PWRUP) || (cnt_d <= CKE_LIM));
    done_d = !rst && (st_d == ST_DONE);
  end

  always_ff @(posedge clk) begin
    cke_q  <= cke_d;
    cmd_q  <= cmd_d;
    addr_q <= addr_d;
    ba_q   <= '0;
    done_q <= done_d;
  end

  // R1: with CKE low only NOP may be on the bus
  a_r1_nop_while_cke_low: assert property (@(posedge clk) disable iff (rst)
    !cke_q |-> (cmd_q == CMD_NOP));

  // R3: CKE never falls once raised
  a_r3_cke_hold: assert property (@(posedge clk) disable iff (rst)
    cke_q |=> cke_q);

  // R4: precharge targets all banks
  a_r4_pre_all: assert property (@(posedge clk) disable iff (rst)
    (cmd_q == CMD_PRE) |-> (addr_q == PRE_ADDR) && (ba_q == '0));

  // R6: mode load carries bank 00 and the op-code
  a_r6_lmr_fields: assert property (@(posedge clk) disable iff (rst)
    (cmd_q == CMD_LMR) |-> (addr_q == MODE_WORD) && (ba_q == '0));

  // R7: done stays high and the bus stays idle after completion
  a_r7_done_hold: assert property (@(posedge clk) disable iff (rst)
    done_q |=> done_q && (cmd_q == CMD_NOP));

endmodule

// File: rtl/sdram_init_seq.sv
module sdram_init_seq
  import sinit_pkg::*;
#(
  parameter int            AW         = 11,
  parameter int            BA_W       = 2,
  parameter int            AP_BIT     = 10,
  parameter int            PWRUP_CYC  = 10000,
  parameter int            CKE_AT_CYC = 5000,
  parameter int            TRP_CYC    = 2,
  parameter int            TRFC_CYC   = 7,
  parameter int            TMRD_CYC   = 2,
  parameter int            REF_COUNT  = 2,
  parameter logic [AW-1:0] MODE_WORD  = 11'h032
) (
  input  logic            clk,
  input  logic            rst,
  output logic            sd_cke,
  output logic            sd_cs_n,
  output logic            sd_ras_n,
  output logic            sd_cas_n,
  output logic            sd_we_n,
  output logic [BA_W-1:0] sd_ba,
  output logic [AW-1:0]   sd_addr,
  output logic            init_done
);
  localparam int M1   = (PWRUP_CYC > TRP_CYC) ? PWRUP_CYC : TRP_CYC;
  localparam int M2   = (TRFC_CYC > TMRD_CYC) ? TRFC_CYC : TMRD_CYC;
  localparam int MAXC = (M1 > M2) ? M1 : M2;
  localparam int CW   = $clog2(MAXC) + 1;
  localparam int RW   = $clog2(REF_COUNT) + 1;
  localparam logic [CW-1:0] PWRUP_LD = CW'(PWRUP_CYC - 1);

  init_st_e      st_d;
  logic          issue_d, load, tmr_zero;
  logic [CW-1:0] load_val, cnt_d;
  logic [3:0]    cmd_q;

  sinit_timer #(.CW(CW)) u_timer (
    .clk(clk), .rst(rst), .rst_val(PWRUP_LD), .load(load),
    .load_val(load_val), .cnt_d(cnt_d), .zero(tmr_zero)
  );

  sinit_fsm #(
    .CW(CW), .RW(RW), .TRP_CYC(TRP_CYC), .TRFC_CYC(TRFC_CYC),
    .TMRD_CYC(TMRD_CYC), .REF_COUNT(REF_COUNT)
  ) u_fsm (
    .clk(clk), .rst(rst), .tmr_zero(tmr_zero), .st_d(st_d),
    .issue_d(issue_d), .load(load), .load_val(load_val)
  );

  sinit_cmd_reg #(
    .CW(CW), .AW(AW), .BA_W(BA_W), .AP_BIT(AP_BIT), .PWRUP_CYC(PWRUP_CYC),
    .CKE_AT_CYC(CKE_AT_CYC), .MODE_WORD(MODE_WORD)
  ) u_out (
    .clk(clk), .rst(rst), .st_d(st_d), .issue_d(issue_d), .cnt_d(cnt_d),
    .cke_q(sd_cke), .cmd_q(cmd_q), .ba_q(sd_ba), .addr_q(sd_addr),
    .done_q(init_done)
  );

  assign {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} = cmd_q;

endmodule

// File: tb/tb_sdram_init_seq.sv
module tb_sdram_init_seq;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_a = 1'b1, rst_b = 1'b1;

  logic a_cke, a_cs, a_ras, a_cas, a_we, a_done;
  logic b_cke, b_cs, b_ras, b_cas, b_we, b_done;
  logic [1:0]  a_ba, b_ba;
  logic [10:0] a_addr, b_addr;

  sdram_init_seq #(
    .PWRUP_CYC(50), .CKE_AT_CYC(20), .TRP_CYC(3), .TRFC_CYC(7),
    .TMRD_CYC(2), .REF_COUNT(2), .MODE_WORD(11'h233)
  ) dut (
    .clk(clk), .rst(rst_a), .sd_cke(a_cke), .sd_cs_n(a_cs), .sd_ras_n(a_ras),
    .sd_cas_n(a_cas), .sd_we_n(a_we), .sd_ba(a_ba), .sd_addr(a_addr),
    .init_done(a_done)
  );

  sdram_init_seq #(
    .PWRUP_CYC(30), .CKE_AT_CYC(1), .TRP_CYC(1), .TRFC_CYC(2),
    .TMRD_CYC(1), .REF_COUNT(4), .MODE_WORD(11'h5A5)
  ) dut_b (
    .clk(clk), .rst(rst_b), .sd_cke(b_cke), .sd_cs_n(b_cs), .sd_ras_n(b_ras),
    .sd_cas_n(b_cas), .sd_we_n(b_we), .sd_ba(b_ba), .sd_addr(b_addr),
    .init_done(b_done)
  );

  localparam logic [3:0] NOP = 4'b0111, PRE = 4'b0010, REF = 4'b0001,
                         LMR = 4'b0000, RDY = 4'b1111;

  // expected events: which dut, slot, command (RDY = done rises), address
  localparam int N_EV = 12;
  localparam bit         EV_DUT [N_EV] = '{0,0,0,0,0, 1,1,1,1,1,1,1};
  localparam int         EV_SLOT[N_EV] = '{50,53,60,67,69, 30,31,33,35,37,39,40};
  localparam logic [3:0] EV_CMD [N_EV] = '{PRE,REF,REF,LMR,RDY,
                                           PRE,REF,REF,REF,REF,LMR,RDY};
  localparam logic [10:0] EV_ADR[N_EV] = '{11'h400,11'h0,11'h0,11'h233,11'h0,
                                           11'h400,11'h0,11'h0,11'h0,11'h0,11'h5A5,11'h0};

  bit sel = 1'b0;
  logic        m_cke, m_done;
  logic [3:0]  m_cmd;
  logic [1:0]  m_ba;
  logic [10:0] m_addr;
  always_comb begin
    m_cke  = sel ? b_cke  : a_cke;
    m_done = sel ? b_done : a_done;
    m_cmd  = sel ? {b_cs,b_ras,b_cas,b_we} : {a_cs,a_ras,a_cas,a_we};
    m_ba   = sel ? b_ba   : a_ba;
    m_addr = sel ? b_addr : a_addr;
  end

  int n_chk = 0, n_fail = 0, slot = 0, cke_rise = -1;
  bit cke_drop = 1'b0, finished = 1'b0;

  task automatic chk(input string tag, input string what, input bit ok,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  function automatic string tag_of(input logic [3:0] c);
    case (c)
      PRE: return "R4";
      REF: return "R5";
      LMR: return "R6";
      default: return "R7";
    endcase
  endfunction

  task automatic step();
    @(negedge clk);
    slot++;
    if (m_cke && cke_rise < 0) cke_rise = slot;
    if (!m_cke && cke_rise >= 0) cke_drop = 1'b1;
  endtask

  // assert reset on the selected dut, release it, check slot 0 (R1)
  task automatic start(input bit which);
    sel = which;
    @(negedge clk);
    if (which) rst_b = 1'b1; else rst_a = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1", "cke/cmd/done in reset", !m_cke && m_cmd == NOP && !m_done,
        {m_cke, m_cmd, m_done}, {1'b0, NOP, 1'b0});
    if (which) rst_b = 1'b0; else rst_a = 1'b0;
    slot = 0; cke_rise = -1; cke_drop = 1'b0;
    chk("R1", "slot0 cke/cmd/done", !m_cke && m_cmd == NOP && !m_done,
        {m_cke, m_cmd, m_done}, {1'b0, NOP, 1'b0});
  endtask

  // advance to the next non-NOP command or the rise of done
  task automatic walk(output logic [3:0] c);
    int guard = 0;
    do begin
      step();
      guard++;
    end while (m_cmd == NOP && !m_done && guard < 500);
    c = (m_cmd != NOP) ? m_cmd : RDY;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [3:0] c;
    bit idle_ok;

    // R2 R3 R4 R5 R6 R7: walk the expected-event table for both parameter sets
    for (int i = 0; i < N_EV; i++) begin
      if (i == 0 || EV_DUT[i] != EV_DUT[i-1]) start(EV_DUT[i]);
      walk(c);
      chk(EV_CMD[i] == PRE ? "R2" : tag_of(EV_CMD[i]), "event slot",
          slot == EV_SLOT[i], slot, EV_SLOT[i]);
      chk(tag_of(EV_CMD[i]), "event command", c == EV_CMD[i], c, EV_CMD[i]);
      if (EV_CMD[i] != RDY) begin
        chk(tag_of(EV_CMD[i]), "address", m_addr == EV_ADR[i], m_addr, EV_ADR[i]);
        chk(tag_of(EV_CMD[i]), "bank", m_ba == 2'b00, m_ba, 0);
      end
      if (EV_CMD[i] == PRE)
        chk("R3", "cke rise slot", cke_rise == (EV_DUT[i] ? 1 : 20),
            cke_rise, EV_DUT[i] ? 1 : 20);
    end

    // R7 R3: after done on dut_b, done and cke hold, bus idle
    idle_ok = 1'b1;
    for (int k = 0; k < 20; k++) begin
      step();
      if (!m_done || m_cmd != NOP) idle_ok = 1'b0;
    end
    chk("R7", "done holds with NOP", idle_ok, idle_ok, 1);
    chk("R3", "cke never dropped", !cke_drop && m_cke, cke_drop, 0);

    // R8: reset dut in the middle of the refresh phase, then full restart
    start(1'b0);
    while (slot < 57) step();
    rst_a = 1'b1;
    @(negedge clk);
    chk("R8", "mid-sequence reset state", !m_cke && m_cmd == NOP && !m_done,
        {m_cke, m_cmd, m_done}, {1'b0, NOP, 1'b0});
    start(1'b0);
    walk(c);
    chk("R8", "restart precharge slot", slot == 50 && c == PRE, slot, 50);
    chk("R8", "restart cke rise", cke_rise == 20, cke_rise, 20);
    walk(c);
    chk("R8", "restart first refresh", slot == 53 && c == REF, slot, 53);

    // R1: long reset keeps everything low
    rst_a = 1'b1;
    idle_ok = 1'b1;
    for (int k = 0; k < 10; k++) begin
      @(negedge clk);
      if (k > 0 && (m_cke || m_cmd != NOP || m_done)) idle_ok = 1'b0;
    end
    chk("R1", "held reset quiet", idle_ok, idle_ok, 1);

    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule